// File: doc/BRIEF.md
# Ethernet Receive Status and Multicast Hash Filter

This block observes one received Ethernet frame at a time, presented as a byte stream with a start strobe, a byte-valid qualifier, an end strobe and a receive-error input. While the frame streams past, it runs an IEEE 802.3 CRC-32 over every byte, counts the bytes and looks at the destination address in the first six bytes. When the end strobe arrives, it publishes a status word, a 6-bit hash value and a pass/drop decision for multicast address filtering, together with a one-cycle done pulse.

The hash is taken from the CRC of the destination address alone. It indexes a 64-bit multicast table that software loads one byte at a time through a small write port. A multicast frame whose table bit is set passes the filter. Unicast station-address matching and promiscuous operation are handled elsewhere.

Top module: `eth_rx_filter`

## Requirements
- R1: After reset, `rx_done`, every status flag, `rs_hash` and `rs_pass` are 0.
- R2: `rx_done` is high for exactly one cycle, the cycle after the one in which `rx_eof` is sampled high. Status, hash and pass change only in that cycle and hold their values until the next done pulse.
- R3: The CRC register is preset to all ones and updated least significant bit first with the reflected polynomial 0xEDB88320 (0x04C11DB7 in normal order). After the sixth destination byte, bit 0 of that reflected register (the CRC's x^31 term) becomes `rs_hash[5]`, bit 1 becomes `rs_hash[4]`, and so on down to bit 5, which becomes `rs_hash[0]`. With the last five address bytes 00, first bytes ED, 0D, 01 and 2F give hashes 000000, 010000, 100111 and 111111.
- R4: `rs_mcast` is bit 0 of the first received byte. `rs_bcast` is set when all six address bytes are FF. A broadcast frame therefore also has `rs_mcast` set.
- R5: `rs_pass` is 1 exactly when `rs_mcast` is 1 and bit `rs_hash[2:0]` of table byte `rs_hash[5:3]` is 1. The table byte at index `mt_wr_idx` takes `mt_wr_data` on a cycle with `mt_wr_en` high.
- R6: `rs_crc_bad` is set when the CRC over the whole frame, frame check sequence included, does not leave the residue 0xDEBB20E3 in the reflected register.
- R7: `rs_crc_bad` is also set when `rx_err` is high in any cycle from the start strobe through the end strobe, even when the frame check sequence is correct.
- R8: `rs_odd` is set when the frame has an odd number of bytes.
- R9: `rs_long` is set when the frame, frame check sequence included, is longer than 1518 bytes.
- R10: `rs_short` is set when the frame, frame check sequence included, is shorter than 64 bytes.
- R11: A start strobe clears the error, address and length history of the previous frame, so no flag from one frame carries into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_sof | input | 1 | Start-of-frame strobe, one cycle before the first byte |
| rx_byte_vld | input | 1 | Byte-valid qualifier for `rx_byte` |
| rx_byte | input | 8 | Received byte |
| rx_eof | input | 1 | End-of-frame strobe, one cycle after the last byte |
| rx_err | input | 1 | Receive-error indication from the line side |
| mt_wr_en | input | 1 | Multicast table byte write enable |
| mt_wr_idx | input | 3 | Multicast table byte index |
| mt_wr_data | input | 8 | Multicast table byte value |
| rx_done | output | 1 | One-cycle pulse: status, hash and pass are new |
| rs_bcast | output | 1 | Broadcast destination |
| rs_mcast | output | 1 | Multicast destination |
| rs_crc_bad | output | 1 | Bad frame check sequence or receive error |
| rs_odd | output | 1 | Odd byte count |
| rs_long | output | 1 | Frame longer than the maximum |
| rs_short | output | 1 | Frame shorter than the minimum |
| rs_hash | output | 6 | Destination-address hash |
| rs_pass | output | 1 | Multicast filter pass decision |

## Verification
The assertions assume well-formed framing on the receive side: a start strobe, then the bytes, then one end strobe, with start, byte-valid and end strobes never high together. The done-pulse property also assumes that no end strobe follows another in the very next cycle. The bench drives every frame through one task that keeps to this order and always leaves at least one idle cycle between frames. Table writes happen only between frames, so each pass decision depends on one known table image.

// File: rtl/eth_rxf_pkg.sv
package eth_rxf_pkg;
    localparam int          HASH_W       = 6;
    localparam int          TBL_BYTES    = 1 << (HASH_W - 3);
    localparam int          TBL_IDX_W    = HASH_W - 3;
    localparam int          DA_BYTES     = 6;
    localparam logic [31:0] CRC_POLY_R   = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET   = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_RESIDUE  = 32'hDEBB20E3;

    typedef struct packed {
        logic              bcast;
        logic              mcast;
        logic              crc_bad;
        logic              odd;
        logic              too_long;
        logic              too_short;
        logic [HASH_W-1:0] hash;
        logic              pass;
    } rx_stat_t;

    // Reflected CRC-32 advanced by one byte, least significant bit first.
    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            r = (r[0] ^ b[i]) ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
        end
        return r;
    endfunction

    // Hash bit (HASH_W-1-i) comes from reflected register bit i.
    function automatic logic [HASH_W-1:0] crc_to_hash(input logic [31:0] c);
        logic [HASH_W-1:0] h;
        for (int i = 0; i < HASH_W; i++) begin
            h[HASH_W-1-i] = c[i];
        end
        return h;
    endfunction
endpackage

// File: rtl/rxf_crc.sv
module rxf_crc
    import eth_rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_nxt,
    output logic [31:0] crc_cur
);
    logic [31:0] crc_d, crc_q;

    always_comb begin
        crc_nxt = crc_byte(crc_q, din);
        crc_d   = crc_q;
        if (clr)     crc_d = CRC_PRESET;
        else if (en) crc_d = crc_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_PRESET;
        else        crc_q <= crc_d;
    end

    assign crc_cur = crc_q;
endmodule

// File: rtl/rxf_lencnt.sv
module rxf_lencnt #(
    parameter int MAX_LEN = 1518,
    parameter int MIN_LEN = 64,
    localparam int CNT_W  = $clog2(MAX_LEN + 1) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] cnt,
    output logic             odd,
    output logic             too_long,
    output logic             too_short
);
    localparam logic [CNT_W-1:0] CNT_SAT = '1;
    localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(MAX_LEN);
    localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(MIN_LEN);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             par_d, par_q;

    always_comb begin
        cnt_d = cnt_q;
        par_d = par_q;
        if (clr) begin
            cnt_d = '0;
            par_d = 1'b0;
        end else if (en) begin
            if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
            par_d = ~par_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            par_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            par_q <= par_d;
        end
    end

    assign cnt       = cnt_q;
    assign odd       = par_q;
    assign too_long  = (cnt_q > MAX_C);
    assign too_short = (cnt_q < MIN_C);
endmodule

// File: rtl/rxf_mtable.sv
module rxf_mtable
    import eth_rxf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [TBL_IDX_W-1:0] wr_idx,
    input  logic [7:0]           wr_data,
    input  logic [HASH_W-1:0]    hash,
    output logic                 hit
);
    logic [TBL_BYTES-1:0][7:0] tbl_q;

    for (genvar g = 0; g < TBL_BYTES; g++) begin : g_byte
        logic [7:0] byte_d;
        always_comb begin
            byte_d = tbl_q[g];
            if (wr_en && (wr_idx == TBL_IDX_W'(g))) byte_d = wr_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tbl_q[g] <= '0;
            else        tbl_q[g] <= byte_d;
        end
    end

    assign hit = tbl_q[hash[HASH_W-1:3]][hash[2:0]];
endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
    import eth_rxf_pkg::*;
#(
    parameter int MAX_LEN = 1518,
    parameter int MIN_LEN = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_sof,
    input  logic        rx_byte_vld,
    input  logic [7:0]  rx_byte,
    input  logic        rx_eof,
    input  logic        rx_err,
    input  logic        mt_wr_en,
    input  logic [2:0]  mt_wr_idx,
    input  logic [7:0]  mt_wr_data,
    output logic        rx_done,
    output logic        rs_bcast,
    output logic        rs_mcast,
    output logic        rs_crc_bad,
    output logic        rs_odd,
    output logic        rs_long,
    output logic        rs_short,
    output logic [5:0]  rs_hash,
    output logic        rs_pass
);
    localparam int CNT_W = $clog2(MAX_LEN + 1) + 1;

    typedef struct packed {
        logic              err;
        logic              mc;
        logic              bc;
        logic [HASH_W-1:0] hash;
        logic              done;
        rx_stat_t          stat;
    } frm_st_t;

    frm_st_t st_d, st_q;

    logic [31:0]      crc_nxt, crc_cur;
    logic [CNT_W-1:0] cnt;
    logic             odd, too_long, too_short, hit;
    logic             byte_en;

    assign byte_en = rx_byte_vld && !rx_sof;

    rxf_crc u_crc (
        .clk(clk), .rst_n(rst_n), .clr(rx_sof), .en(byte_en),
        .din(rx_byte), .crc_nxt(crc_nxt), .crc_cur(crc_cur)
    );

    rxf_lencnt #(.MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN)) u_len (
        .clk(clk), .rst_n(rst_n), .clr(rx_sof), .en(byte_en),
        .cnt(cnt), .odd(odd), .too_long(too_long), .too_short(too_short)
    );

    rxf_mtable u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(mt_wr_en), .wr_idx(mt_wr_idx),
        .wr_data(mt_wr_data), .hash(st_q.hash), .hit(hit)
    );

    always_comb begin
        logic da_done;
        st_d      = st_q;
        st_d.done = 1'b0;
        da_done   = (cnt >= CNT_W'(DA_BYTES));
        if (rx_sof) begin
            st_d.err  = 1'b0;
            st_d.mc   = 1'b0;
            st_d.bc   = 1'b1;
            st_d.hash = '0;
        end else if (rx_byte_vld) begin
            if (cnt == '0)                 st_d.mc   = rx_byte[0];
            if (!da_done)                  st_d.bc   = st_q.bc && (rx_byte == 8'hFF);
            if (cnt == CNT_W'(DA_BYTES-1)) st_d.hash = crc_to_hash(crc_nxt);
        end
        if (rx_err) st_d.err = 1'b1;
        if (rx_eof) begin
            st_d.done           = 1'b1;
            st_d.stat.mcast     = st_q.mc;
            st_d.stat.bcast     = st_q.bc && da_done;
            st_d.stat.crc_bad   = st_q.err || rx_err || (crc_cur != CRC_RESIDUE);
            st_d.stat.odd       = odd;
            st_d.stat.too_long  = too_long;
            st_d.stat.too_short = too_short;
            st_d.stat.hash      = st_q.hash;
            st_d.stat.pass      = st_q.mc && hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_done    = st_q.done;
    assign rs_bcast   = st_q.stat.bcast;
    assign rs_mcast   = st_q.stat.mcast;
    assign rs_crc_bad = st_q.stat.crc_bad;
    assign rs_odd     = st_q.stat.odd;
    assign rs_long    = st_q.stat.too_long;
    assign rs_short   = st_q.stat.too_short;
    assign rs_hash    = st_q.stat.hash;
    assign rs_pass    = st_q.stat.pass;
endmodule

// File: rtl/eth_rx_filter_chk.sv
module eth_rx_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_eof,
    input logic       rx_err,
    input logic       rx_done,
    input logic       rs_bcast,
    input logic       rs_mcast,
    input logic       rs_crc_bad,
    input logic       rs_odd,
    input logic       rs_long,
    input logic       rs_short,
    input logic [5:0] rs_hash,
    input logic       rs_pass
);
    AST_DONE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> $past(rx_eof)); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done); // R2
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |-> $stable({rs_bcast, rs_mcast, rs_crc_bad, rs_odd, rs_long, rs_short, rs_hash, rs_pass})); // R2
    AST_BCAST_IS_MCAST: assert property (@(posedge clk) disable iff (!rst_n)
        rs_bcast |-> rs_mcast); // R4
    AST_PASS_NEEDS_MCAST: assert property (@(posedge clk) disable iff (!rst_n)
        rs_pass |-> rs_mcast); // R5
    AST_ERR_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && $past(rx_err)) |-> rs_crc_bad); // R7
    AST_LEN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rs_long && rs_short)); // R9
endmodule

bind eth_rx_filter eth_rx_filter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_eof(rx_eof), .rx_err(rx_err), .rx_done(rx_done),
    .rs_bcast(rs_bcast), .rs_mcast(rs_mcast), .rs_crc_bad(rs_crc_bad), .rs_odd(rs_odd),
    .rs_long(rs_long), .rs_short(rs_short), .rs_hash(rs_hash), .rs_pass(rs_pass)
);

// File: tb/eth_rx_filter_tb.sv
module eth_rx_filter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_sof = 0, rx_byte_vld = 0, rx_eof = 0, rx_err = 0;
    logic [7:0] rx_byte = '0;
    logic       mt_wr_en = 0;
    logic [2:0] mt_wr_idx = '0;
    logic [7:0] mt_wr_data = '0;
    logic       rx_done, rs_bcast, rs_mcast, rs_crc_bad, rs_odd, rs_long, rs_short, rs_pass;
    logic [5:0] rs_hash;

    int  n_run = 0, n_fail = 0;
    bit  fin = 0;
    logic [7:0] frm [0:1599];

    always #10 clk = ~clk; // 50 MHz

    eth_rx_filter u_dut (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_byte_vld(rx_byte_vld),
        .rx_byte(rx_byte), .rx_eof(rx_eof), .rx_err(rx_err), .mt_wr_en(mt_wr_en),
        .mt_wr_idx(mt_wr_idx), .mt_wr_data(mt_wr_data), .rx_done(rx_done),
        .rs_bcast(rs_bcast), .rs_mcast(rs_mcast), .rs_crc_bad(rs_crc_bad), .rs_odd(rs_odd),
        .rs_long(rs_long), .rs_short(rs_short), .rs_hash(rs_hash), .rs_pass(rs_pass)
    );

    function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if ((r[0] ^ b[i]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
            else                        r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [5:0] hash_ref();
        logic [31:0] c;
        logic [5:0]  h;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < 6; i++) c = crc_ref(c, frm[i]);
        for (int i = 0; i < 6; i++) h[5-i] = c[i];
        return h;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] b0, input logic [7:0] brest);
        frm[0] = b0;
        for (int i = 1; i < 6; i++) frm[i] = brest;
        for (int i = 6; i < 1600; i++) frm[i] = 8'(i) ^ 8'h5A;
    endtask

    // Returns at the falling edge where rx_done should be high.
    task automatic send(input int len, input bit good, input int err_at);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < len - 4; i++) c = crc_ref(c, frm[i]);
        c = ~c;
        if (!good) c[3] = ~c[3];
        for (int k = 0; k < 4; k++) frm[len-4+k] = c[8*k +: 8];
        @(negedge clk) rx_sof = 1'b1;
        @(negedge clk) rx_sof = 1'b0;
        for (int i = 0; i < len; i++) begin
            rx_byte_vld = 1'b1;
            rx_byte     = frm[i];
            rx_err      = (i == err_at);
            @(negedge clk);
        end
        rx_byte_vld = 1'b0;
        rx_err      = 1'b0;
        rx_eof      = 1'b1;
        @(negedge clk) rx_eof = 1'b0;
    endtask

    task automatic wr_tbl(input logic [63:0] t);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            mt_wr_en = 1'b1; mt_wr_idx = 3'(i); mt_wr_data = t[8*i +: 8];
        end
        @(negedge clk) mt_wr_en = 1'b0;
    endtask

    task automatic chk_len(input int len);
        fill(8'h01, 8'h00);
        send(len, 1'b1, -1);
        chk(rs_odd == 1'((len % 2) == 1), "R8 odd", rs_odd, (len % 2));
        chk(rs_long == 1'(len > 1518), "R9 long", rs_long, int'(len > 1518));
        chk(rs_short == 1'(len < 64), "R10 short", rs_short, int'(len < 64));
        chk(rs_crc_bad == 1'b0, "R6 good fcs", rs_crc_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] vb [4];
        logic [5:0] vh [4];
        vb = '{8'hED, 8'h0D, 8'h01, 8'h2F};
        vh = '{6'b000000, 6'b010000, 6'b100111, 6'b111111};

        repeat (3) @(negedge clk);
        // R1: reset state
        chk({rx_done, rs_bcast, rs_mcast, rs_crc_bad, rs_odd, rs_long, rs_short, rs_hash, rs_pass} == '0,
            "R1 reset", {rs_hash, rs_pass}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: fixed hash vectors; R2 pulse timing
        foreach (vb[k]) begin
            fill(vb[k], 8'h00);
            send(64, 1'b1, -1);
            chk(rx_done == 1'b1, "R2 done high", rx_done, 1);
            chk(rs_hash == vh[k], "R3 hash vector", rs_hash, vh[k]);
            chk(rs_hash == hash_ref(), "R3 hash model", rs_hash, hash_ref());
            chk(rs_mcast == 1'b1, "R4 mcast", rs_mcast, 1);
            chk(rs_crc_bad == 1'b0, "R6 crc ok", rs_crc_bad, 0);
            @(negedge clk);
            chk(rx_done == 1'b0, "R2 done one cycle", rx_done, 0);
        end

        // R5: sweep all 64 first-byte multicast patterns with one-hot and one-cold tables
        for (int d = 0; d < 64; d++) begin
            logic [5:0] h;
            logic [63:0] t;
            fill(8'((d << 2) | 1), 8'(d));
            h = hash_ref();
            t = 64'd1 << h;
            wr_tbl(t);
            send(64, 1'b1, -1);
            chk(rs_hash == h, "R3 hash sweep", rs_hash, h);
            chk(rs_pass == 1'b1, "R5 pass one-hot", rs_pass, 1);
            wr_tbl(~t);
            send(64, 1'b1, -1);
            chk(rs_pass == 1'b0, "R5 drop one-cold", rs_pass, 0);
        end

        // R4/R5: unicast never passes, even with a full table
        wr_tbl('1);
        fill(8'h02, 8'h11);
        send(64, 1'b1, -1);
        chk(rs_mcast == 1'b0, "R4 unicast mcast", rs_mcast, 0);
        chk(rs_pass == 1'b0, "R5 unicast pass", rs_pass, 0);
        chk(rs_bcast == 1'b0, "R4 unicast bcast", rs_bcast, 0);

        // R4: broadcast raises both flags; near-broadcast does not
        fill(8'hFF, 8'hFF);
        send(64, 1'b1, -1);
        chk(rs_bcast == 1'b1, "R4 bcast", rs_bcast, 1);
        chk(rs_mcast == 1'b1, "R4 bcast mcast", rs_mcast, 1);
        chk(rs_pass == 1'b1, "R5 bcast full table", rs_pass, 1);
        fill(8'hFF, 8'hFF);
        frm[5] = 8'hFE;
        send(64, 1'b1, -1);
        chk(rs_bcast == 1'b0, "R4 near bcast", rs_bcast, 0);

        // R6: corrupted FCS
        fill(8'h01, 8'h00);
        send(70, 1'b0, -1);
        chk(rs_crc_bad == 1'b1, "R6 bad fcs", rs_crc_bad, 1);

        // R7: rx_err mid-frame with good FCS; R11 next frame clean
        fill(8'h01, 8'h00);
        send(70, 1'b1, 30);
        chk(rs_crc_bad == 1'b1, "R7 rx_err", rs_crc_bad, 1);
        fill(8'h01, 8'h00);
        send(70, 1'b1, -1);
        chk(rs_crc_bad == 1'b0, "R11 error cleared", rs_crc_bad, 0);

        // R2: outputs hold while the next frame streams
        fill(8'h03, 8'h00);
        rx_sof = 1'b0;
        @(negedge clk) rx_sof = 1'b1;
        @(negedge clk) rx_sof = 1'b0;
        for (int i = 0; i < 20; i++) begin
            rx_byte_vld = 1'b1; rx_byte = frm[i]; @(negedge clk);
        end
        rx_byte_vld = 1'b0;
        chk(rs_crc_bad == 1'b0 && rs_mcast == 1'b1 && rx_done == 1'b0, "R2 hold", rs_crc_bad, 0);
        rx_eof = 1'b1;
        @(negedge clk) rx_eof = 1'b0;
        chk(rs_short == 1'b1 && rs_crc_bad == 1'b1, "R10 truncated", rs_short, 1);

        // R8/R9/R10: length boundaries
        chk_len(63);
        chk_len(64);
        chk_len(65);
        chk_len(1518);
        chk_len(1519);

        fin = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule